// File: doc/BRIEF.md
# Core Deep-Sleep Entry/Exit Sequencer

This block is a per-core controller that takes one core into its deepest idle state and brings it back. Each thread of the core can ask for the deep state in two ways. One is a legacy power-level I/O read trigger. The other is a wait-instruction hint whose value names the deep state. The core starts entry only once every thread has an outstanding request. A thread without a request keeps the core awake.

Entry runs in two steps. First the state-save engine copies the architectural registers into the retention SRAM. Only after it reports completion is the rail gate asserted to take the core supply down. A break (wake) event takes the core back out. The rail is powered up first, then the saved state is restored, and only then is the core reported active. A break that arrives during the save aborts the entry, and the rail is never touched. A break that arrives while the rail is going down is held until the rail is fully off. Exit then starts at once.

Every phase drives a plain request level to its partner stub: save engine, regulator-off, regulator-on or restore engine. The phase holds until the matching done strobe arrives. These are control pins, not streams, so there is no valid/ready back-pressure. A request simply stays high until its done strobe is seen.

Top module: `deep_idle_seq`

## Requirements
- R1: After reset the phase is ACTIVE, `core_active` is 1, `rail_gate` is 0, and all four request outputs are 0.
- R2: Entry into SAVING happens only when every thread holds a pending request. With any thread not requesting, the phase stays ACTIVE. Pending requests are cleared by a break event and on entry to SAVING.
- R3: A thread's request is set by a pulse on its `io_lvl_rd` bit, or by its `wait_vld` bit together with a `wait_hint` field equal to `DEEP_HINT`. A wait with any other hint value sets nothing. Requests are captured only in ACTIVE.
- R4: In SAVING, `save_req` is 1 and `rail_gate` is 0. The `save_done` strobe moves the phase to POWER_DOWN. At most one of the four request outputs is 1 at any time.
- R5: `rail_gate` is 1 exactly in POWER_DOWN and OFF. It rises only on the cycle after a `save_done` seen in SAVING. `pwr_off_req` is 1 in POWER_DOWN, and `pwr_off_done` moves the phase to OFF.
- R6: A break in SAVING returns the phase to ACTIVE on the next cycle, with `rail_gate` staying 0. A break has priority over a simultaneous `save_done`.
- R7: A break in POWER_DOWN leaves the phase in POWER_DOWN until `pwr_off_done`. Once in OFF, the held break starts POWER_UP on the next cycle without a new event.
- R8: A break in OFF moves the phase to POWER_UP, where `rail_gate` is 0 and `pwr_on_req` is 1. `pwr_on_done` moves it to RESTORING, where `restore_req` is 1. `restore_done` returns it to ACTIVE.
- R9: `core_active` is 1 only in ACTIVE. Through an exit, it is set only once `restore_done` has completed RESTORING.
- R10: Done strobes that do not match the current phase have no effect. A break in POWER_UP or RESTORING is ignored.
- R11: The `phase` output encoding is ACTIVE=0, SAVING=1, POWER_DOWN=2, OFF=3, POWER_UP=4, RESTORING=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_lvl_rd | input | NUM_THREADS | Per-thread legacy I/O-read deep-idle trigger |
| wait_vld | input | NUM_THREADS | Per-thread wait-instruction strobe |
| wait_hint | input | NUM_THREADS*HINT_W | Per-thread wait hint, thread i in bits [i*HINT_W +: HINT_W] |
| brk_evt | input | 1 | Break / wake event |
| save_req | output | 1 | Request to state-save engine |
| save_done | input | 1 | State save complete |
| pwr_off_req | output | 1 | Request to lower the core rail |
| pwr_off_done | input | 1 | Rail is off |
| pwr_on_req | output | 1 | Request to raise the core rail |
| pwr_on_done | input | 1 | Rail is up |
| restore_req | output | 1 | Request to restore engine |
| restore_done | input | 1 | Restore complete |
| rail_gate | output | 1 | 1 = core rail gated off |
| phase | output | 3 | Current phase code |
| core_active | output | 1 | Core is running |

## Verification
The request logic is swept over every combination of per-thread request forms with two threads. The forms are none, I/O trigger, wait with the deep hint, and wait with another hint. This separates an AND over threads from an OR, and separates a correct hint compare from one that ignores the hint. Each entry is then driven through one of three exit shapes: an abort during the save, a break held across rail-down, and a plain break in OFF. These tell apart the abort path, the deferred wake and the ordinary exit. Stray done strobes in the wrong phases, and breaks during exit, show whether the handshakes are gated by the phase.

// File: rtl/deep_idle_pkg.sv
package deep_idle_pkg;
  typedef enum logic [2:0] {
    PH_ACTIVE    = 3'd0,
    PH_SAVING    = 3'd1,
    PH_PWR_DOWN  = 3'd2,
    PH_OFF       = 3'd3,
    PH_PWR_UP    = 3'd4,
    PH_RESTORING = 3'd5
  } phase_e;
endpackage

// File: rtl/thread_req_collect.sv
module thread_req_collect #(
  parameter int NUM_THREADS = 2,
  parameter int HINT_W      = 4,
  parameter logic [HINT_W-1:0] DEEP_HINT = 4'h6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        io_lvl_rd,
  input  logic [NUM_THREADS-1:0]        wait_vld,
  input  logic [NUM_THREADS*HINT_W-1:0] wait_hint,
  input  logic                          capture_en,
  input  logic                          clear,
  output logic                          all_req
);
  logic [NUM_THREADS-1:0] pend_q;
  logic [NUM_THREADS-1:0] hit;

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
    assign hit[i] = io_lvl_rd[i] |
                    (wait_vld[i] && (wait_hint[i*HINT_W +: HINT_W] == DEEP_HINT));

    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (clear)      pend_q[i] <= 1'b0;
      else if (capture_en && hit[i]) pend_q[i] <= 1'b1;
    end
  end

  assign all_req = &pend_q;
endmodule

// File: rtl/wake_hold.sv
module wake_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hold,
  input  logic drop_hold,
  output logic held
);
  always_ff @(posedge clk) begin
    if (!rst_n)         held <= 1'b0;
    else if (drop_hold) held <= 1'b0;
    else if (set_hold)  held <= 1'b1;
  end
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import deep_idle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   all_req,
  input  logic   brk_evt,
  input  logic   brk_held,
  input  logic   save_done,
  input  logic   pwr_off_done,
  input  logic   pwr_on_done,
  input  logic   restore_done,
  output phase_e ph_q,
  output logic   start_entry,
  output logic   hold_set,
  output logic   hold_drop
);
  phase_e ph_d;

  always_comb begin
    ph_d        = ph_q;
    start_entry = 1'b0;
    hold_set    = 1'b0;
    hold_drop   = 1'b0;
    unique case (ph_q)
      PH_ACTIVE: if (all_req && !brk_evt) begin
        ph_d        = PH_SAVING;
        start_entry = 1'b1;
      end
      PH_SAVING: begin
        if (brk_evt)        ph_d = PH_ACTIVE;
        else if (save_done) ph_d = PH_PWR_DOWN;
      end
      PH_PWR_DOWN: begin
        hold_set = brk_evt;
        if (pwr_off_done) ph_d = PH_OFF;
      end
      PH_OFF: if (brk_held || brk_evt) begin
        ph_d      = PH_PWR_UP;
        hold_drop = 1'b1;
      end
      PH_PWR_UP:    if (pwr_on_done)  ph_d = PH_RESTORING;
      PH_RESTORING: if (restore_done) ph_d = PH_ACTIVE;
      default:      ph_d = PH_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_ACTIVE;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/deep_idle_seq.sv
module deep_idle_seq
  import deep_idle_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int HINT_W      = 4,
  parameter logic [HINT_W-1:0] DEEP_HINT = 4'h6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        io_lvl_rd,
  input  logic [NUM_THREADS-1:0]        wait_vld,
  input  logic [NUM_THREADS*HINT_W-1:0] wait_hint,
  input  logic                          brk_evt,
  output logic                          save_req,
  input  logic                          save_done,
  output logic                          pwr_off_req,
  input  logic                          pwr_off_done,
  output logic                          pwr_on_req,
  input  logic                          pwr_on_done,
  output logic                          restore_req,
  input  logic                          restore_done,
  output logic                          rail_gate,
  output logic [2:0]                    phase,
  output logic                          core_active
);
  phase_e ph;
  logic   all_req, start_entry, hold_set, hold_drop, held;
  logic   in_active;

  assign in_active = (ph == PH_ACTIVE);

  thread_req_collect #(
    .NUM_THREADS(NUM_THREADS), .HINT_W(HINT_W), .DEEP_HINT(DEEP_HINT)
  ) u_req (
    .clk(clk), .rst_n(rst_n),
    .io_lvl_rd(io_lvl_rd), .wait_vld(wait_vld), .wait_hint(wait_hint),
    .capture_en(in_active),
    .clear(brk_evt || start_entry),
    .all_req(all_req)
  );

  wake_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .set_hold(hold_set), .drop_hold(hold_drop), .held(held)
  );

  phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .all_req(all_req), .brk_evt(brk_evt), .brk_held(held),
    .save_done(save_done), .pwr_off_done(pwr_off_done),
    .pwr_on_done(pwr_on_done), .restore_done(restore_done),
    .ph_q(ph), .start_entry(start_entry),
    .hold_set(hold_set), .hold_drop(hold_drop)
  );

  assign save_req    = (ph == PH_SAVING);
  assign pwr_off_req = (ph == PH_PWR_DOWN);
  assign pwr_on_req  = (ph == PH_PWR_UP);
  assign restore_req = (ph == PH_RESTORING);
  assign rail_gate   = (ph == PH_PWR_DOWN) || (ph == PH_OFF);
  assign core_active = in_active;
  assign phase       = ph;
endmodule

// File: rtl/deep_idle_chk.sv
module deep_idle_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_evt,
  input logic       save_req,
  input logic       save_done,
  input logic       pwr_off_req,
  input logic       pwr_off_done,
  input logic       pwr_on_req,
  input logic       restore_req,
  input logic       restore_done,
  input logic       rail_gate,
  input logic [2:0] phase,
  input logic       core_active
);
  // R5: rail goes down only right after a completed save
  assert_gate_after_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_gate) |-> ($past(phase) == 3'd1 && $past(save_done)));

  // R8: rail comes back only by entering power-up
  assert_ungate_powerup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_gate) |-> (phase == 3'd4));

  // R6: break during save aborts to active
  assert_abort_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && brk_evt) |=> (phase == 3'd0 && !rail_gate));

  // R7: break in power-down never skips the off phase
  assert_hold_pdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2 && brk_evt) |=> (phase == 3'd2 || phase == 3'd3));

  // R9: active is regained only via restore completion or save abort
  assert_active_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_active) |-> ($past(phase) == 3'd5 || $past(phase) == 3'd1));

  // R4: request outputs are mutually exclusive
  assert_one_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_req, pwr_off_req, pwr_on_req, restore_req}));

  // R10: break during exit does not disturb power-up
  assert_exit_ignores_brk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd4 && brk_evt) |=> (phase == 3'd4 || phase == 3'd5));
endmodule

bind deep_idle_seq deep_idle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_evt(brk_evt),
  .save_req(save_req), .save_done(save_done),
  .pwr_off_req(pwr_off_req), .pwr_off_done(pwr_off_done),
  .pwr_on_req(pwr_on_req), .restore_req(restore_req),
  .restore_done(restore_done), .rail_gate(rail_gate),
  .phase(phase), .core_active(core_active)
);

// File: tb/sim_deep_idle_seq.sv
`timescale 1ns/1ps
module sim_deep_idle_seq;
  localparam int NT = 2;
  localparam int HW = 4;
  localparam logic [HW-1:0] DEEP = 4'h6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0] io_lvl_rd = '0, wait_vld = '0;
  logic [NT*HW-1:0] wait_hint = '0;
  logic brk_evt = 0, save_done = 0, pwr_off_done = 0, pwr_on_done = 0, restore_done = 0;
  logic save_req, pwr_off_req, pwr_on_req, restore_req, rail_gate, core_active;
  logic [2:0] phase;

  int errs = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  deep_idle_seq #(.NUM_THREADS(NT), .HINT_W(HW), .DEEP_HINT(DEEP)) u0 (
    .clk(clk), .rst_n(rst_n), .io_lvl_rd(io_lvl_rd), .wait_vld(wait_vld),
    .wait_hint(wait_hint), .brk_evt(brk_evt),
    .save_req(save_req), .save_done(save_done),
    .pwr_off_req(pwr_off_req), .pwr_off_done(pwr_off_done),
    .pwr_on_req(pwr_on_req), .pwr_on_done(pwr_on_done),
    .restore_req(restore_req), .restore_done(restore_done),
    .rail_gate(rail_gate), .phase(phase), .core_active(core_active));

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outputs per phase code (R11 encoding)
  task automatic chk_phase(input string req, input int ph);
    chk({req, " phase"}, phase, ph);
    chk({req, " rail_gate"}, rail_gate, (ph == 2 || ph == 3) ? 1 : 0);
    chk({req, " core_active"}, core_active, (ph == 0) ? 1 : 0);
    chk({req, " req_vec"}, {save_req, pwr_off_req, pwr_on_req, restore_req},
        (ph == 1) ? 8 : (ph == 2) ? 4 : (ph == 4) ? 2 : (ph == 5) ? 1 : 0);
  endtask

  task automatic stray_done();
    save_done = 1; pwr_off_done = 1; pwr_on_done = 1; restore_done = 1;
  endtask
  task automatic clr_in();
    save_done = 0; pwr_off_done = 0; pwr_on_done = 0; restore_done = 0;
    brk_evt = 0; io_lvl_rd = '0; wait_vld = '0; wait_hint = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) cyc();
    chk_phase("R1 reset", 0);
    rst_n = 1;
    cyc();
    chk_phase("R1 after release", 0);

    // R10: done strobes in ACTIVE do nothing
    stray_done(); cyc(); clr_in(); cyc();
    chk_phase("R10 stray in ACTIVE", 0);

    for (int f0 = 0; f0 < 4; f0++) begin
      for (int f1 = 0; f1 < 4; f1++) begin
        for (int shape = 0; shape < 3; shape++) begin
          // form: 0 none, 1 io trigger, 2 wait+deep hint, 3 wait+other hint (R3)
          int fm[2];
          bit enter;
          fm[0] = f0; fm[1] = f1;
          for (int t = 0; t < NT; t++) begin
            io_lvl_rd[t] = (fm[t] == 1);
            wait_vld[t]  = (fm[t] >= 2);
            wait_hint[t*HW +: HW] = (fm[t] == 2) ? DEEP : 4'h3;
          end
          enter = (f0 == 1 || f0 == 2) && (f1 == 1 || f1 == 2);
          cyc(); clr_in(); cyc();
          if (!enter) begin
            chk_phase("R2 R3 no entry", 0);
            brk_evt = 1; cyc(); clr_in(); cyc();
            chk_phase("R2 cleared by break", 0);
            continue;
          end
          chk_phase("R2 R3 R4 entry to SAVING", 1);
          // R10: wrong-phase strobes in SAVING
          pwr_off_done = 1; pwr_on_done = 1; restore_done = 1; cyc(); clr_in();
          chk_phase("R10 stray in SAVING", 1);
          if (shape == 0) begin
            brk_evt = 1; save_done = 1; cyc(); clr_in();
            chk_phase("R6 abort", 0);
            cyc();
            chk_phase("R6 stays active (pending cleared)", 0);
            continue;
          end
          save_done = 1; cyc(); clr_in();
          chk_phase("R4 R5 POWER_DOWN", 2);
          if (shape == 1) begin
            brk_evt = 1; cyc(); clr_in();
            chk_phase("R7 held in POWER_DOWN", 2);
            cyc();
            chk_phase("R7 still POWER_DOWN", 2);
            pwr_off_done = 1; cyc(); clr_in();
            chk_phase("R7 OFF", 3);
            cyc();
            chk_phase("R7 held break starts POWER_UP", 4);
          end else begin
            pwr_off_done = 1; cyc(); clr_in();
            chk_phase("R5 OFF", 3);
            save_done = 1; restore_done = 1; pwr_on_done = 1; cyc(); clr_in();
            chk_phase("R10 stray in OFF", 3);
            cyc();
            chk_phase("R8 OFF waits", 3);
            brk_evt = 1; cyc(); clr_in();
            chk_phase("R8 POWER_UP", 4);
          end
          brk_evt = 1; restore_done = 1; cyc(); clr_in();
          chk_phase("R10 break ignored in POWER_UP", 4);
          pwr_on_done = 1; cyc(); clr_in();
          chk_phase("R8 RESTORING", 5);
          brk_evt = 1; cyc(); clr_in();
          chk_phase("R9 R10 not active before restore", 5);
          restore_done = 1; cyc(); clr_in();
          chk_phase("R8 R9 back to ACTIVE", 0);
          cyc();
          chk_phase("R2 no re-entry without new request", 0);
        end
      end
    end

    // R3: request outside ACTIVE is not captured
    io_lvl_rd = '1; cyc(); clr_in(); cyc();
    chk_phase("R3 entry for capture test", 1);
    io_lvl_rd = '1; save_done = 1; cyc(); clr_in();
    pwr_off_done = 1; cyc(); clr_in();
    brk_evt = 1; cyc(); clr_in();
    pwr_on_done = 1; cyc(); clr_in();
    restore_done = 1; cyc(); clr_in();
    cyc();
    chk_phase("R3 mid-sequence request discarded", 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule